// File: doc/BRIEF.md
# Register-Write Command Packer

This block turns a stream of register-write requests into a packed instruction buffer that a separate executor later fetches. Each request carries a 20-bit register offset, a 32-bit data word and a mode bit. A direct request becomes a fixed two-word instruction. An indexed request either opens a new counted burst or, when it targets the same register as the burst still open, adds one more data word to that burst and patches the burst's count word in place. Bursts start on even word addresses, and a zero pad word follows any burst that ends on an odd address.

The buffer is an internal word RAM. It has one write port, which is driven by a small sequencer that stores one word per cycle, and one read port that software-side logic or a test can use to inspect the image. A commit pulse finalises the buffer. It zero-fills up to the next 64-byte line, publishes the tail as a byte count, and rewinds the write and instruction positions to word zero. A request that arrives once the buffer is full is discarded and sets a sticky overflow flag, which the next commit clears.

Top module: `cbp_packer`

## Requirements
- R1: A direct request (req_indexed=0) takes the current free position F as its instruction start. It writes the data word at F and the header word at F+1, then sets the free position to F+2. The header holds opcode 0x01 in bits 31:24, byte enables 0xF in bits 23:20 and the offset in bits 19:0.
- R2: An indexed request that does not merge first rounds the free position up to an even word E, which becomes the instruction start. It writes the count 1 at E, the header at E+1 (opcode 0x09 in bits 31:24, zero in bits 23:20, offset in bits 19:0) and the data at E+2.
- R3: An indexed request merges when the open instruction is an indexed burst with the same offset. It writes its data at the free position, stores the incremented count at the instruction start, and advances the free position by one.
- R4: A direct request or a commit closes the open burst. A later indexed request to the same offset then starts a new burst under R2.
- R5: When an indexed request leaves the free position odd, the word at that position is written with zero.
- R6: A request accepted while the free position is at or beyond DEPTH writes nothing and sets overflow. Overflow stays high until a commit completes.
- R7: A commit while the free position is zero does nothing: commit_done stays low, tail_bytes keeps its value and requests remain accepted.
- R8: A commit with a non-empty buffer sets tail_bytes to the used byte count (4 × free position) rounded up to a multiple of 64. It writes zero to every word from the free position up to the tail, then pulses commit_done for one cycle.
- R9: After commit_done, the free position and the instruction start are both zero, so the next instruction begins at word 0.
- R10: req_ready is low while a request's words are being stored, while a commit's zero-fill runs, and in any cycle in which commit is high.
- R11: After reset, req_ready is 1, and overflow, commit_done and tail_bytes are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | A request is taken on this edge when req_valid is also high |
| req_indexed | input | 1 | 1 selects indexed (burst) mode, 0 selects direct mode |
| req_offset | input | 20 | Target register offset |
| req_data | input | 32 | Value to be written |
| commit | input | 1 | Single-cycle pulse that finalises the buffer; honoured while the packer is idle |
| commit_done | output | 1 | One-cycle pulse when a commit has finished |
| tail_bytes | output | $clog2(DEPTH)+4 | Padded buffer length in bytes from the last commit |
| overflow | output | 1 | Sticky flag: a request was dropped because the buffer was full |
| rd_addr | input | $clog2(DEPTH) | Inspection read address (word) |
| rd_data | output | 32 | Word at rd_addr, one cycle later |

## Verification
The packer is driven with mixed sequences. A direct write is followed by a run of indexed writes to one register, which must merge, and then an indexed write to a different register, which must start a new burst. This distinguishes merging from restarting and exercises both pad parities. An indexed write to the same register after an intervening direct write, and another after a commit, shows that these events close a burst even when the offset matches. Commits are issued on an empty buffer, on a buffer that already ends on a line boundary (no zero-fill), on one that needs fill, and on a completely full buffer followed by dropped requests. Together these separate the rounding, the fill range and the overflow behaviour.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

   localparam int WORD_W  = 32;
   localparam int OFS_W   = 20;

   localparam logic [7:0] OP_DIRECT = 8'h01;
   localparam logic [7:0] OP_BURST  = 8'h09;
   localparam logic [3:0] BE_ALL    = 4'hF;
   localparam logic [3:0] BE_NONE   = 4'h0;

   // Maximum number of RAM words a single request can produce.
   localparam int MAX_WR = 4;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EMIT,
      ST_FILL
   } seq_state_e;

   function automatic logic [WORD_W-1:0] make_hdr(input logic [7:0] op,
                                                  input logic [3:0] be,
                                                  input logic [OFS_W-1:0] ofs);
      return {op, be, ofs};
   endfunction

endpackage

// File: rtl/cbp_word_ram.sv
module cbp_word_ram #(
   parameter int DEPTH   = 2048,
   parameter int AW      = 11,
   parameter int PW      = 13,
   parameter int WORD_W  = 32,
   parameter bit RD_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);

   logic [WORD_W-1:0] mem [DEPTH];
   logic              in_range;

   // Positions can run past the end of storage; such writes are discarded.
   assign in_range = (waddr < PW'(DEPTH));

   always_ff @(posedge clk) begin
      if (we && in_range) begin
         mem[waddr[AW-1:0]] <= wdata;
      end
   end

   generate
      if (RD_PIPE) begin : g_rd_reg
         always_ff @(posedge clk) begin
            rdata <= mem[raddr];
         end
      end else begin : g_rd_comb
         assign rdata = mem[raddr];
      end
   endgenerate

endmodule

// File: rtl/cbp_planner.sv
module cbp_planner
   import cbp_pkg::*;
#(
   parameter int PW = 13
) (
   input  logic                         req_indexed,
   input  logic [OFS_W-1:0]             req_offset,
   input  logic [WORD_W-1:0]            req_data,
   input  logic [PW-1:0]                fp,
   input  logic [PW-1:0]                start,
   input  logic                         burst_open,
   input  logic [OFS_W-1:0]             burst_ofs,
   input  logic [WORD_W-1:0]            burst_cnt,
   output logic [2:0]                   n_wr,
   output logic [MAX_WR-1:0][PW-1:0]    wr_addr,
   output logic [MAX_WR-1:0][WORD_W-1:0] wr_data,
   output logic [PW-1:0]                nxt_fp,
   output logic [PW-1:0]                nxt_start,
   output logic                         nxt_open,
   output logic [OFS_W-1:0]             nxt_ofs,
   output logic [WORD_W-1:0]            nxt_cnt
);

   logic            merge;
   logic [PW-1:0]   even_fp;
   logic [PW-1:0]   fp_plus1;

   assign merge    = req_indexed && burst_open && (req_offset == burst_ofs);
   assign even_fp  = fp + PW'(fp[0]);
   assign fp_plus1 = fp + PW'(1);

   always_comb begin
      n_wr      = 3'd0;
      wr_addr   = '0;
      wr_data   = '0;
      nxt_fp    = fp;
      nxt_start = start;
      nxt_open  = burst_open;
      nxt_ofs   = burst_ofs;
      nxt_cnt   = burst_cnt;

      if (!req_indexed) begin
         // Two-word direct instruction: value then header.
         wr_addr[0] = fp;
         wr_data[0] = req_data;
         wr_addr[1] = fp_plus1;
         wr_data[1] = make_hdr(OP_DIRECT, BE_ALL, req_offset);
         n_wr       = 3'd2;
         nxt_fp     = fp + PW'(2);
         nxt_start  = fp;
         nxt_open   = 1'b0;
      end else if (merge) begin
         // Append to the open burst and patch its count word.
         wr_addr[0] = fp;
         wr_data[0] = req_data;
         wr_addr[1] = start;
         wr_data[1] = burst_cnt + 32'd1;
         n_wr       = 3'd2;
         nxt_fp     = fp_plus1;
         nxt_cnt    = burst_cnt + 32'd1;
         if (fp_plus1[0]) begin
            wr_addr[2] = fp_plus1;
            wr_data[2] = '0;
            n_wr       = 3'd3;
         end
      end else begin
         // New burst on an even boundary: count, header, value, pad.
         wr_addr[0] = even_fp;
         wr_data[0] = 32'd1;
         wr_addr[1] = even_fp + PW'(1);
         wr_data[1] = make_hdr(OP_BURST, BE_NONE, req_offset);
         wr_addr[2] = even_fp + PW'(2);
         wr_data[2] = req_data;
         wr_addr[3] = even_fp + PW'(3);
         wr_data[3] = '0;
         n_wr       = 3'd4;
         nxt_fp     = even_fp + PW'(3);
         nxt_start  = even_fp;
         nxt_open   = 1'b1;
         nxt_ofs    = req_offset;
         nxt_cnt    = 32'd1;
      end
   end

endmodule

// File: rtl/cbp_packer.sv
module cbp_packer
   import cbp_pkg::*;
#(
   parameter int DEPTH      = 2048,
   parameter int LINE_BYTES = 64,
   parameter bit RD_PIPE    = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic                         req_indexed,
   input  logic [19:0]                  req_offset,
   input  logic [31:0]                  req_data,
   input  logic                         commit,
   output logic                         commit_done,
   output logic [$clog2(DEPTH)+3:0]     tail_bytes,
   output logic                         overflow,
   input  logic [$clog2(DEPTH)-1:0]     rd_addr,
   output logic [31:0]                  rd_data
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 2;
   localparam int TW = PW + 2;
   localparam int LW = LINE_BYTES / 4;

   generate
      if ((1 << AW) != DEPTH || DEPTH < 4) begin : g_bad_depth
         $error("cbp_packer: DEPTH must be a power of two of at least 4");
      end
      if ((LINE_BYTES % 8) != 0 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("cbp_packer: LINE_BYTES must be a power of two multiple of 8");
      end
      if (LW > DEPTH) begin : g_bad_ratio
         $error("cbp_packer: a line may not exceed the buffer");
      end
   endgenerate

   seq_state_e                    state_q;
   logic [PW-1:0]                 fp_q, start_q;
   logic                          open_q;
   logic [OFS_W-1:0]              ofs_q;
   logic [WORD_W-1:0]             cnt_q;
   logic                          ovf_q;
   logic [TW-1:0]                 tail_q;
   logic                          done_q;
   logic [MAX_WR-1:0][PW-1:0]     wa_q;
   logic [MAX_WR-1:0][WORD_W-1:0] wd_q;
   logic [2:0]                    nwr_q;
   logic [1:0]                    idx_q;
   logic [PW-1:0]                 fill_ptr_q, fill_end_q;

   logic [2:0]                    pl_nwr;
   logic [MAX_WR-1:0][PW-1:0]     pl_wa;
   logic [MAX_WR-1:0][WORD_W-1:0] pl_wd;
   logic [PW-1:0]                 pl_fp, pl_start;
   logic                          pl_open;
   logic [OFS_W-1:0]              pl_ofs;
   logic [WORD_W-1:0]             pl_cnt;

   logic                          idle;
   logic                          fill_busy;
   logic                          full;
   logic [PW-1:0]                 tail_words;
   logic                          ram_we;
   logic [PW-1:0]                 ram_wa;
   logic [WORD_W-1:0]             ram_wd;

   assign idle       = (state_q == ST_IDLE);
   assign fill_busy  = (state_q == ST_FILL);
   assign full       = (fp_q >= PW'(DEPTH));
   assign req_ready  = idle && !commit;
   assign tail_words = (fp_q + PW'(LW - 1)) & ~PW'(LW - 1);

   assign commit_done = done_q;
   assign tail_bytes  = tail_q;
   assign overflow    = ovf_q;

   cbp_planner #(.PW(PW)) i_planner (
      .req_indexed (req_indexed),
      .req_offset  (req_offset),
      .req_data    (req_data),
      .fp          (fp_q),
      .start       (start_q),
      .burst_open  (open_q),
      .burst_ofs   (ofs_q),
      .burst_cnt   (cnt_q),
      .n_wr        (pl_nwr),
      .wr_addr     (pl_wa),
      .wr_data     (pl_wd),
      .nxt_fp      (pl_fp),
      .nxt_start   (pl_start),
      .nxt_open    (pl_open),
      .nxt_ofs     (pl_ofs),
      .nxt_cnt     (pl_cnt)
   );

   always_comb begin
      ram_we = 1'b0;
      ram_wa = '0;
      ram_wd = '0;
      case (state_q)
         ST_EMIT: begin
            ram_we = 1'b1;
            ram_wa = wa_q[idx_q];
            ram_wd = wd_q[idx_q];
         end
         ST_FILL: begin
            ram_we = (fill_ptr_q < fill_end_q);
            ram_wa = fill_ptr_q;
         end
         default: ;
      endcase
   end

   cbp_word_ram #(
      .DEPTH   (DEPTH),
      .AW      (AW),
      .PW      (PW),
      .WORD_W  (WORD_W),
      .RD_PIPE (RD_PIPE)
   ) i_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_wa),
      .wdata (ram_wd),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         fp_q       <= '0;
         start_q    <= '0;
         open_q     <= 1'b0;
         ofs_q      <= '0;
         cnt_q      <= '0;
         ovf_q      <= 1'b0;
         tail_q     <= '0;
         done_q     <= 1'b0;
         wa_q       <= '0;
         wd_q       <= '0;
         nwr_q      <= '0;
         idx_q      <= '0;
         fill_ptr_q <= '0;
         fill_end_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (commit) begin
                  if (fp_q != '0) begin
                     tail_q     <= {tail_words, 2'b00};
                     fill_ptr_q <= fp_q;
                     fill_end_q <= tail_words;
                     state_q    <= ST_FILL;
                  end
               end else if (req_valid) begin
                  if (full) begin
                     ovf_q <= 1'b1;
                  end else begin
                     wa_q    <= pl_wa;
                     wd_q    <= pl_wd;
                     nwr_q   <= pl_nwr;
                     idx_q   <= '0;
                     fp_q    <= pl_fp;
                     start_q <= pl_start;
                     open_q  <= pl_open;
                     ofs_q   <= pl_ofs;
                     cnt_q   <= pl_cnt;
                     state_q <= ST_EMIT;
                  end
               end
            end
            ST_EMIT: begin
               if ({1'b0, idx_q} == nwr_q - 3'd1) begin
                  state_q <= ST_IDLE;
               end else begin
                  idx_q <= idx_q + 2'd1;
               end
            end
            ST_FILL: begin
               if (fill_ptr_q < fill_end_q) begin
                  fill_ptr_q <= fill_ptr_q + PW'(1);
               end else begin
                  fp_q    <= '0;
                  start_q <= '0;
                  open_q  <= 1'b0;
                  ovf_q   <= 1'b0;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cbp_packer_chk.sv
module cbp_packer_chk #(
   parameter int DEPTH      = 2048,
   parameter int LINE_BYTES = 64,
   parameter int PW         = 13,
   parameter int TW         = 15
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          commit,
   input logic          commit_done,
   input logic [TW-1:0] tail_bytes,
   input logic          overflow,
   input logic [PW-1:0] fp,
   input logic          idle,
   input logic          fill_busy
);

   localparam int LB = $clog2(LINE_BYTES);

   // R6: a drop on a full buffer raises the flag
   a_r6_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && fp >= PW'(DEPTH)) |=> overflow);

   // R6: the flag only falls together with a finished commit
   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> (overflow || commit_done));

   // R10: no request is taken while the zero-fill runs
   a_r10_stall_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
      fill_busy |-> !req_ready);

   // R10: commit blocks the request path in the same cycle
   a_r10_commit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !req_ready);

   // R9: positions are back at zero when done is seen
   a_r9_positions_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      commit_done |-> (fp == '0));

   // R8: published tail is a non-zero whole number of lines
   a_r8_tail_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      commit_done |-> (tail_bytes[LB-1:0] == '0 && tail_bytes != '0));

   // R8: done is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      commit_done |=> !commit_done);

   // R7: an empty commit starts no fill and keeps the tail
   a_r7_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && commit && fp == '0) |=> (!fill_busy && $stable(tail_bytes)));

endmodule

bind cbp_packer cbp_packer_chk #(
   .DEPTH      (DEPTH),
   .LINE_BYTES (LINE_BYTES),
   .PW         (PW),
   .TW         (TW)
) i_cbp_packer_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .commit      (commit),
   .commit_done (commit_done),
   .tail_bytes  (tail_bytes),
   .overflow    (overflow),
   .fp          (fp_q),
   .idle        (idle),
   .fill_busy   (fill_busy)
);

// File: tb/test_cbp_packer.sv
module test_cbp_packer;

   localparam int DEPTH = 2048;
   localparam int AW    = $clog2(DEPTH);
   localparam int TW    = AW + 4;
   localparam int LW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_indexed = 1'b0;
   logic [19:0]   req_offset = '0;
   logic [31:0]   req_data = '0;
   logic          commit = 1'b0;
   logic          commit_done;
   logic [TW-1:0] tail_bytes;
   logic          overflow;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;

   always #2 clk = ~clk;

   cbp_packer #(.DEPTH(DEPTH)) i_cbp_packer (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_indexed (req_indexed),
      .req_offset  (req_offset),
      .req_data    (req_data),
      .commit      (commit),
      .commit_done (commit_done),
      .tail_bytes  (tail_bytes),
      .overflow    (overflow),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data)
   );

   int          n_checks = 0;
   int          n_fail   = 0;
   int          done_cnt = 0;
   bit          finished = 1'b0;
   int unsigned exp_tail_q[$];

   // Requirement-level model of the buffer image and positions
   int unsigned mdl [DEPTH];
   int          m_fp = 0, m_start = 0, m_cnt = 0;
   bit          m_open = 1'b0;
   int unsigned m_off = 0;
   int unsigned last_tail = 0;

   task automatic check(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic m_put(input int a, input int unsigned d);
      if (a < DEPTH) mdl[a] = d;
   endtask

   task automatic model_req(input bit idx, input int unsigned ofs, input int unsigned d);
      if (m_fp >= DEPTH) return;                       // R6 drop
      if (!idx) begin                                  // R1
         m_put(m_fp, d);
         m_put(m_fp + 1, 32'h01F0_0000 | ofs);
         m_start = m_fp;
         m_fp += 2;
         m_open = 1'b0;                                // R4
      end else if (m_open && ofs == m_off) begin       // R3
         m_put(m_fp, d);
         m_cnt++;
         m_put(m_start, m_cnt);
         m_fp++;
         if (m_fp % 2) m_put(m_fp, 0);                 // R5
      end else begin                                   // R2
         m_fp += m_fp % 2;
         m_start = m_fp;
         m_put(m_fp, 1);
         m_put(m_fp + 1, 32'h0900_0000 | ofs);
         m_put(m_fp + 2, d);
         m_fp += 3;
         m_put(m_fp, 0);                               // R5
         m_open = 1'b1;
         m_off = ofs;
         m_cnt = 1;
      end
   endtask

   task automatic send(input bit idx, input int unsigned ofs, input int unsigned d,
                       input bit chk_stall);
      @(negedge clk);
      req_valid   = 1'b1;
      req_indexed = idx;
      req_offset  = ofs[19:0];
      req_data    = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (chk_stall) check("R10 ready low while storing", req_ready, 0);
      model_req(idx, ofs, d);
   endtask

   task automatic read_image(input string tag, input int words);
      for (int a = 0; a < words && a < DEPTH; a++) begin
         @(negedge clk);
         rd_addr = a[AW-1:0];
         @(negedge clk);
         check(tag, rd_data, mdl[a]);
      end
   endtask

   task automatic do_commit(input string tag);
      int tw;
      int seen;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      if (m_fp == 0) begin
         commit = 1'b1;
         seen = done_cnt;
         @(negedge clk);
         commit = 1'b0;
         repeat (20) @(negedge clk);
         check("R7 empty commit gives no done", done_cnt, seen);
         check("R7 tail unchanged", tail_bytes, last_tail);
         check("R7 ready after empty commit", req_ready, 1);
         return;
      end
      tw = ((m_fp + LW - 1) / LW) * LW;
      for (int a = m_fp; a < tw; a++) m_put(a, 0);     // R8 fill
      exp_tail_q.push_back(tw * 4);
      seen = done_cnt;
      commit = 1'b1;
      @(negedge clk);
      commit = 1'b0;
      while (done_cnt == seen) @(negedge clk);
      read_image(tag, tw);
      m_fp = 0; m_start = 0; m_open = 1'b0;            // R9
      last_tail = tw * 4;
   endtask

   // Monitor: pops expected tails as commits complete
   always @(negedge clk) begin
      if (rst_n && commit_done) begin
         done_cnt++;
         if (exp_tail_q.size() == 0) begin
            check("R8 unexpected done", 1, 0);
         end else begin
            check("R8 tail bytes", tail_bytes, exp_tail_q.pop_front());
         end
         check("R6 overflow cleared by commit", overflow, 0);
      end
   end

   task automatic report;
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      report();
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) mdl[a] = 0;
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 ready after reset", req_ready, 1);
      check("R11 overflow after reset", overflow, 0);
      check("R11 done after reset", commit_done, 0);
      check("R11 tail after reset", tail_bytes, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 empty buffer
      do_commit("R7");

      // R1 direct, R2 new burst, R3 merges, R5 pads, R4 restart after direct
      send(1'b0, 32'h00100, 32'hAAAA_0001, 1'b1);
      send(1'b1, 32'h00200, 32'h1111_0001, 1'b1);
      send(1'b1, 32'h00200, 32'h1111_0002, 1'b0);
      send(1'b1, 32'h00200, 32'h1111_0003, 1'b0);
      send(1'b1, 32'h00300, 32'h2222_0001, 1'b0);
      send(1'b0, 32'h00300, 32'hBBBB_0002, 1'b0);
      send(1'b1, 32'h00300, 32'h3333_0001, 1'b0);
      check("R3 model count sanity", mdl[2], 3);
      do_commit("R1 R2 R3 R4 R5 R8 image");

      // R9 restart at word 0, R4 commit closes burst; exact line end needs no fill
      send(1'b1, 32'h00300, 32'h4444_0001, 1'b0);
      send(1'b1, 32'h00300, 32'h4444_0002, 1'b0);
      for (int k = 0; k < 6; k++) send(1'b0, 32'h00400 + k, 32'h5555_0000 + k, 1'b0);
      check("R9 model fp on line boundary", m_fp, 16);
      do_commit("R9 R4 R8 image");
      do_commit("R7");

      // R6 fill the buffer completely, then offer more
      for (int k = 0; k < DEPTH / 2; k++) send(1'b0, k, 32'hC000_0000 + k, 1'b0);
      check("R6 no overflow when exactly full", overflow, 0);
      send(1'b1, 32'h00777, 32'hDEAD_0001, 1'b0);
      check("R6 overflow after drop", overflow, 1);
      send(1'b0, 32'h00778, 32'hDEAD_0002, 1'b0);
      check("R6 overflow sticky", overflow, 1);
      do_commit("R6 R8 full image");
      check("R6 overflow low after commit", overflow, 0);

      repeat (5) @(negedge clk);
      report();
   end

endmodule